// File: doc/BRIEF.md
# Bus Cycle Termination Controller

This block watches one asynchronous processor bus cycle at a time and decides how it ends. It samples the address strobe, the data-size acknowledge, the autovector acknowledge, an external bus error, halt and an interrupt-acknowledge marker on the falling clock edge. From the order in which acknowledge, bus error and halt show up, it selects one of five outcomes: normal, halt, bus error, retry, or spurious vector.

An internal bus monitor counts the falling-edge samples taken while the strobe is asserted. If no acknowledge or bus error arrives within a programmable number of samples, it raises its own registered bus error. That error then takes part in the termination like an external one. After the first acknowledge or bus error, the block takes one more sample to catch a late bus error or halt. It then emits exactly one registered termination code as a one-cycle pulse and ignores the bus until the strobe is seen negated.

Top module: `bus_term_ctrl`

## Requirements
- R1: While reset is applied and after it is released, `term_valid_o` and `mon_berr_o` are 0.
- R2: All bus inputs are captured on the falling clock edge. When an acknowledge (`ack_i` or `avec_i`) is sampled and no bus error or halt is sampled with it, or in the following sample, the code 0 (normal) is pulsed. The pulse comes on the rising edge after the sample that follows the acknowledge.
- R3: Halt sampled together with or before the acknowledge, with no bus error, gives code 1 (halt). Halt alone never ends a cycle.
- R4: Bus error without halt gives code 2 (bus error). A bus error ends a cycle even with no acknowledge, and a bus error sampled one sample after the acknowledge still counts.
- R5: Bus error together with halt gives code 3 (retry). A halt that first appears in the sample after the acknowledge counts only when a bus error is also present.
- R6: In an interrupt-acknowledge cycle (`iack_i`=1), bus error without halt gives code 4 (spurious vector), and bus error with halt gives code 3 (retry).
- R7: With `mon_en_i`=1 and `mon_limit_i`=L, if L strobe samples pass with no acknowledge and no bus error, `mon_berr_o` rises on the rising edge after the L-th sample. It stays high until the strobe is sampled negated. The cycle ends as a bus error (code 2, 4 or 3 under R4 to R6). An acknowledge in sample L prevents the timeout.
- R8: With `mon_en_i`=0, the monitor never raises `mon_berr_o`, and a cycle waits for an acknowledge or bus error indefinitely.
- R9: Each bus cycle yields exactly one termination pulse, never two in consecutive clocks. Further inputs are ignored until the strobe is sampled negated.
- R10: An acknowledge still asserted at the first strobe sample of the next cycle terminates that cycle at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bus inputs sampled on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| as_i | input | 1 | Address strobe asserted (active high) |
| ack_i | input | 1 | Data-size acknowledge asserted |
| avec_i | input | 1 | Autovector acknowledge asserted |
| berr_i | input | 1 | External bus error asserted |
| halt_i | input | 1 | Halt asserted |
| iack_i | input | 1 | Current cycle is an interrupt acknowledge |
| mon_en_i | input | 1 | Bus monitor enable |
| mon_limit_i | input | CNT_W | Bus monitor timeout in strobe samples |
| term_valid_o | output | 1 | One-cycle termination pulse |
| term_code_o | output | 3 | 0 normal, 1 halt, 2 bus error, 3 retry, 4 spurious |
| mon_berr_o | output | 1 | Bus error raised by the internal monitor |

## Verification
The assertions assume that `mon_en_i` and `mon_limit_i` stay fixed for the whole of a bus cycle. They also assume that the bus inputs change only just after a rising edge, so that every falling-edge sample sees settled values. The stimulus follows this: inputs are driven two nanoseconds after each rising edge, and the monitor settings are changed only while the strobe is negated. Acknowledge, bus error and halt are held from their first asserted sample until the strobe drops, which matches the requirement that they negate no earlier than the acknowledge.

// File: rtl/bus_term_pkg.sv
package bus_term_pkg;

  typedef enum logic [2:0] {
    TERM_NORMAL = 3'd0,
    TERM_HALT   = 3'd1,
    TERM_BERR   = 3'd2,
    TERM_RETRY  = 3'd3,
    TERM_SPUR   = 3'd4
  } term_code_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_LATE,
    ST_DRAIN
  } term_state_e;

  typedef struct packed {
    logic strobe;
    logic ack;
    logic avec;
    logic berr;
    logic halt;
    logic iack;
  } bus_smp_t;

  function automatic term_code_e classify(input logic b, input logic h, input logic iack);
    if (b && h)         return TERM_RETRY;
    else if (b && iack) return TERM_SPUR;
    else if (b)         return TERM_BERR;
    else if (h)         return TERM_HALT;
    else                return TERM_NORMAL;
  endfunction

endpackage

// File: rtl/bt_sampler.sv
module bt_sampler #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(negedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

endmodule

// File: rtl/bt_bus_monitor.sv
module bt_bus_monitor #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             count_en,
  input  logic             enable,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);

  localparam int EW = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [EW-1:0]    next_cnt;

  assign next_cnt = {1'b0, cnt} + EW'(1);
  assign expire   = enable && count_en && (next_cnt >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || clear)
      cnt <= '0;
    else if (enable && count_en && !expire)
      cnt <= next_cnt[CNT_W-1:0];
  end

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
    enable |-> (cnt <= limit));

  assert_cleared_R7: assert property (@(posedge clk) disable iff (rst)
    $past(clear) |-> (cnt == '0));

endmodule

// File: rtl/bus_term_ctrl.sv
module bus_term_ctrl
  import bus_term_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             as_i,
  input  logic             ack_i,
  input  logic             avec_i,
  input  logic             berr_i,
  input  logic             halt_i,
  input  logic             iack_i,
  input  logic             mon_en_i,
  input  logic [CNT_W-1:0] mon_limit_i,
  output logic             term_valid_o,
  output logic [2:0]       term_code_o,
  output logic             mon_berr_o
);

  localparam int SW = $bits(bus_smp_t);

  bus_smp_t    raw, smp;
  term_state_e state;
  logic        seen_b, seen_h, iack_q;
  logic        in_cycle, got_ack, stop, expire, mon_clear, count_en;
  logic        fin_b, fin_h;

  assign raw = '{strobe: as_i, ack: ack_i, avec: avec_i,
                 berr: berr_i, halt: halt_i, iack: iack_i};

  bt_sampler #(.W(SW)) u_sampler (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (smp)
  );

  assign in_cycle  = smp.strobe && (state == ST_IDLE || state == ST_WAIT);
  assign got_ack   = smp.ack || smp.avec;
  assign count_en  = in_cycle && !got_ack && !smp.berr;
  assign stop      = in_cycle && (got_ack || smp.berr || expire);
  assign mon_clear = (state == ST_DRAIN) || (state == ST_IDLE && !smp.strobe);

  bt_bus_monitor #(.CNT_W(CNT_W)) u_monitor (
    .clk      (clk),
    .rst      (rst),
    .clear    (mon_clear),
    .count_en (count_en),
    .enable   (mon_en_i),
    .limit    (mon_limit_i),
    .expire   (expire)
  );

  // late sample: bus error always counts, halt only alongside a bus error
  assign fin_b = seen_b || smp.berr;
  assign fin_h = seen_h || (fin_b && smp.halt);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      seen_b       <= 1'b0;
      seen_h       <= 1'b0;
      iack_q       <= 1'b0;
      term_valid_o <= 1'b0;
      term_code_o  <= TERM_NORMAL;
      mon_berr_o   <= 1'b0;
    end else begin
      term_valid_o <= 1'b0;
      case (state)
        ST_IDLE, ST_WAIT: begin
          if (in_cycle) begin
            seen_h <= ((state == ST_WAIT) && seen_h) || smp.halt;
            seen_b <= smp.berr || expire;
            iack_q <= smp.iack;
            if (expire) mon_berr_o <= 1'b1;
            state <= stop ? ST_LATE : ST_WAIT;
          end else begin
            seen_h <= 1'b0;
            seen_b <= 1'b0;
            state  <= ST_IDLE;
          end
        end
        ST_LATE: begin
          term_valid_o <= 1'b1;
          term_code_o  <= classify(fin_b, fin_h, iack_q);
          state        <= ST_DRAIN;
        end
        default: begin
          if (!smp.strobe) begin
            state      <= ST_IDLE;
            mon_berr_o <= 1'b0;
            seen_b     <= 1'b0;
            seen_h     <= 1'b0;
          end
        end
      endcase
    end
  end

  assert_one_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    term_valid_o |=> !term_valid_o);

  assert_code_range_R2: assert property (@(posedge clk) disable iff (rst)
    term_valid_o |-> (term_code_o <= 3'd4));

  assert_spur_iack_R6: assert property (@(posedge clk) disable iff (rst)
    (term_valid_o && term_code_o == TERM_SPUR) |-> iack_q);

  assert_mon_enabled_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(mon_berr_o) |-> mon_en_i);

  assert_mon_term_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(mon_berr_o) |=> (term_valid_o && term_code_o != TERM_NORMAL
                           && term_code_o != TERM_HALT));

  assert_halt_no_berr_R3: assert property (@(posedge clk) disable iff (rst)
    (term_valid_o && term_code_o == TERM_HALT) |-> !mon_berr_o);

endmodule

// File: tb/bus_term_ctrl_tb.sv
module bus_term_ctrl_tb;

  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic as_i = 0, ack_i = 0, avec_i = 0, berr_i = 0, halt_i = 0, iack_i = 0;
  logic mon_en_i = 0;
  logic [CNT_W-1:0] mon_limit_i = '0;
  logic term_valid_o;
  logic [2:0] term_code_o;
  logic mon_berr_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  logic [2:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  bus_term_ctrl #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .as_i(as_i), .ack_i(ack_i), .avec_i(avec_i),
    .berr_i(berr_i), .halt_i(halt_i), .iack_i(iack_i), .mon_en_i(mon_en_i),
    .mon_limit_i(mon_limit_i), .term_valid_o(term_valid_o),
    .term_code_o(term_code_o), .mon_berr_o(mon_berr_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drv(input bit as, input bit ack, input bit avec,
                     input bit berr, input bit halt, input bit iack);
    @(posedge clk);
    #2;
    as_i = as; ack_i = ack; avec_i = avec; berr_i = berr; halt_i = halt; iack_i = iack;
  endtask

  task automatic expect_term(input string tag, input logic [2:0] code);
    exp_q.push_back(code);
    tag_q.push_back(tag);
  endtask

  // signals held from their first sample until the strobe drops; 0 = never
  task automatic run_cycle(input string tag, input int ack_at, input int berr_at,
                           input int halt_at, input bit iack, input bit use_avec,
                           input logic [2:0] code);
    expect_term(tag, code);
    for (int i = 1; i <= 6; i++) begin
      bit a, b, h;
      a = (ack_at != 0) && (i >= ack_at);
      b = (berr_at != 0) && (i >= berr_at);
      h = (halt_at != 0) && (i >= halt_at);
      drv(1, a && !use_avec, a && use_avec, b, h, iack);
    end
    repeat (3) drv(0, 0, 0, 0, 0, 0);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && term_valid_o) begin
        if (exp_q.size() == 0) begin
          chk("R9 unexpected termination pulse", 1, 0);
        end else begin
          logic [2:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, int'(term_code_o), int'(e));
        end
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 term_valid during reset", int'(term_valid_o), 0);
    chk("R1 mon_berr during reset", int'(mon_berr_o), 0);
    rst = 1'b0;
    mon_en_i = 1'b1;
    mon_limit_i = 8'd20;
    repeat (2) @(posedge clk);
    #2;
    chk("R1 term_valid after reset", int'(term_valid_o), 0);
    chk("R1 mon_berr after reset", int'(mon_berr_o), 0);

    run_cycle("R2 normal ack", 2, 0, 0, 0, 0, 3'd0);
    run_cycle("R2 normal avec", 3, 0, 0, 1, 1, 3'd0);
    run_cycle("R3 halt with ack", 2, 0, 2, 0, 0, 3'd1);
    run_cycle("R3 halt before ack", 3, 0, 1, 0, 0, 3'd1);
    run_cycle("R2 late halt alone stays normal", 2, 0, 3, 0, 0, 3'd0);
    run_cycle("R4 berr in lieu of ack", 0, 2, 0, 0, 0, 3'd2);
    run_cycle("R4 berr before ack", 3, 2, 0, 0, 0, 3'd2);
    run_cycle("R4 berr with ack", 2, 2, 0, 0, 0, 3'd2);
    run_cycle("R4 berr after ack", 2, 3, 0, 0, 0, 3'd2);
    run_cycle("R5 retry in lieu", 0, 2, 2, 0, 0, 3'd3);
    run_cycle("R5 retry after ack", 2, 3, 3, 0, 0, 3'd3);
    run_cycle("R5 halt early berr late", 3, 4, 1, 0, 0, 3'd3);
    run_cycle("R6 iack berr spurious", 0, 2, 0, 1, 0, 3'd4);
    run_cycle("R6 iack berr halt retry", 0, 2, 2, 1, 0, 3'd3);

    // R3: halt alone does not end the cycle
    expect_term("R3 halt then late ack", 3'd1);
    for (int i = 1; i <= 8; i++) begin
      drv(1, i >= 5, 0, 0, 1, 0);
      if (i <= 6) chk("R3 no pulse while only halt", int'(term_valid_o), 0);
    end
    repeat (3) drv(0, 0, 0, 0, 0, 0);

    // R7: monitor timeout with limit 5
    mon_limit_i = 8'd5;
    expect_term("R7 timeout gives bus error", 3'd2);
    for (int i = 1; i <= 8; i++) begin
      drv(1, 0, 0, 0, 0, 0);
      if (i == 5) chk("R7 mon_berr before limit", int'(mon_berr_o), 0);
      if (i == 6) chk("R7 mon_berr after limit", int'(mon_berr_o), 1);
      if (i == 8) chk("R7 mon_berr held", int'(mon_berr_o), 1);
    end
    drv(0, 0, 0, 0, 0, 0);
    drv(0, 0, 0, 0, 0, 0);
    chk("R7 mon_berr cleared after strobe", int'(mon_berr_o), 0);
    drv(0, 0, 0, 0, 0, 0);

    run_cycle("R7 ack at limit sample", 5, 0, 0, 0, 0, 3'd0);
    chk("R7 no timeout when ack at limit", int'(mon_berr_o), 0);

    expect_term("R7 timeout in iack is spurious", 3'd4);
    for (int i = 1; i <= 8; i++) drv(1, 0, 0, 0, 0, 1);
    repeat (3) drv(0, 0, 0, 0, 0, 0);

    // R8: monitor off, long wait
    mon_en_i = 1'b0;
    expect_term("R8 disabled monitor waits for ack", 3'd0);
    for (int i = 1; i <= 20; i++) drv(1, 0, 0, 0, 0, 0);
    chk("R8 mon_berr stays low", int'(mon_berr_o), 0);
    chk("R8 no pulse before ack", int'(exp_q.size()), 1);
    drv(1, 1, 0, 0, 0, 0);
    drv(1, 1, 0, 0, 0, 0);
    drv(1, 1, 0, 0, 0, 0);
    repeat (3) drv(0, 0, 0, 0, 0, 0);

    // R10: leftover ack ends the next cycle early (monitor still off)
    expect_term("R10 first cycle", 3'd0);
    expect_term("R10 leftover ack ends next cycle", 3'd0);
    drv(1, 0, 0, 0, 0, 0);
    for (int i = 1; i <= 4; i++) drv(1, 1, 0, 0, 0, 0);
    drv(0, 1, 0, 0, 0, 0);
    drv(1, 1, 0, 0, 0, 0);
    for (int i = 1; i <= 5; i++) drv(1, 0, 0, 0, 0, 0);
    repeat (3) drv(0, 0, 0, 0, 0, 0);

    repeat (5) @(posedge clk);
    chk("R9 all expected terminations seen", int'(exp_q.size()), 0);
    finish_run();
  end

endmodule